// File: doc/BRIEF.md
# Merkle Branch Verifier for Page Descriptors

This block guards the per-page descriptors (random values and permutation data) that a secure processor keeps for each memory page against replay. The descriptors are covered by a binary hash tree whose root digest lives only in an on-chip register. When a page descriptor is loaded into the extended translation buffer, a verify operation hashes the descriptor into a leaf digest. It then climbs the branch, combining the running digest with the sibling at each level. It stops at the first node it already trusts: either the root register or an entry in a small fully associative cache of trusted nodes. When a descriptor changes, an update operation recomputes the branch. Each new node digest is written into the trusted cache as dirty, and the root register takes the new top digest. Dirty nodes reach the tree memory only when the least recently used policy evicts them.

Nodes are numbered heap style. The root is node 1, the children of node k are 2k and 2k+1, and the leaf of page p is node 2^DEPTH + p. The compression function is a placeholder. It maps two 64-bit digests to one in `HASH_CYC` cycles. The control is one state machine:
- IDLE accepts an operation and goes to HASH.
- HASH waits for the compression unit and then goes to CHECK.
- CHECK ends the walk at the root or, for a verify, at a cached node, going to FINISH. Otherwise it goes to SIB, or to EVICT when an update must first free a dirty slot.
- EVICT writes the victim to memory and returns to CHECK.
- SIB takes the sibling from the cache and goes to HASH, or goes to RD.
- RD issues the memory read and goes to RSP.
- RSP waits for the data and goes to HASH.
- FINISH pulses done and returns to IDLE.

A failed verify (done with pass low) is the signal that halts the affected secure process.

Top module: `merkle_branch_verifier`

## Requirements
- R1: After reset op_ready is high, done is low, no memory request is made, and the root register holds zero. A verify issued before any update therefore ends with pass low.
- R2: A leaf digest is F(descriptor, page number zero-extended to 64 bits). A parent digest is F(digest of even child 2k, digest of odd child 2k+1). Here F is the placeholder compression: x = a ^ swap32(b) ^ 0x9E3779B97F4A7C15; x ^= x>>29; x += b<<3; x ^= rotl(x,13).
- R3: A verify climbs from the leaf and ends with pass high exactly when the running digest equals the root register or the digest of the first cached node on the branch.
- R4: Any digest mismatch ends the verify with done high and pass low.
- R5: An update stores every recomputed node below the root in the trusted cache as dirty. It loads the root register with the new top digest and ends with pass high. Later verifies of the new descriptor pass.
- R6: A verify whose leaf node is already cached ends without any memory request.
- R7: A sibling is taken from the cache when present, otherwise read from memory at its node number (mem_req_write low). A request stays asserted, with a stable address and direction, until mem_req_ready. Read data is taken on mem_rsp_valid.
- R8: Cache replacement picks an invalid slot first, else the least recently used one. Lookups that hit and writes both count as uses. A dirty victim is written to memory at its node number (mem_req_write high) with its digest before its slot is reused.
- R9: Only one operation runs at a time. op_ready falls after acceptance and stays low until done. done is a one-cycle pulse, followed by op_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Block idle, request accepted this cycle |
| op_update | input | 1 | 1 = update branch, 0 = verify branch |
| op_page | input | DEPTH | Page number |
| op_meta | input | 64 | Page descriptor digest input |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| mem_req_valid | output | 1 | Tree memory request |
| mem_req_ready | input | 1 | Tree memory accepts request |
| mem_req_write | output | 1 | 1 = write back node, 0 = read node |
| mem_req_addr | output | DEPTH+1 | Node number |
| mem_req_wdata | output | 64 | Node digest to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read node digest |

## Verification
The assertions watch, on every cycle, the handshake rules: a pending memory request holding its address and direction, the absence of memory traffic while idle, the single-cycle done, and the busy window after acceptance. Only the directed scenarios can show that the digests are right and that tampering is caught. The same holds for the walk stopping early, which the bench sees as exact memory read counts. The least recently used eviction order and the digest of each written-back node also need the scenarios.

// File: rtl/mbv_pkg.sv
package mbv_pkg;
    typedef logic [63:0] digest_t;

    function automatic digest_t mbv_compress(digest_t a, digest_t b);
        digest_t x;
        x = a ^ {b[31:0], b[63:32]} ^ 64'h9E37_79B9_7F4A_7C15;
        x = x ^ (x >> 29);
        x = x + {b[60:0], 3'b000};
        x = x ^ {x[50:0], x[63:51]};
        return x;
    endfunction
endpackage

// File: rtl/mbv_hash.sv
module mbv_hash
    import mbv_pkg::*;
#(
    parameter int HASH_CYC = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  digest_t in_a,
    input  digest_t in_b,
    output logic    done,
    output digest_t result
);
    localparam int CW = $clog2(HASH_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            result <= '0;
        end else if (start) begin
            cnt_q  <= CW'(HASH_CYC);
            result <= mbv_compress(in_a, in_b);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/mbv_node_cache.sv
module mbv_node_cache
    import mbv_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 5,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output digest_t          hit_data,
    output logic [IW-1:0]    vic_idx,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    output digest_t          vic_data,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  digest_t          wr_data,
    input  logic             touch_en,
    input  logic [IW-1:0]    touch_idx,
    input  logic             inval_en,
    input  logic [IW-1:0]    inval_idx
);
    logic             valid_q [ENTRIES];
    logic             dirty_q [ENTRIES];
    logic [TAG_W-1:0] tag_q   [ENTRIES];
    digest_t          data_q  [ENTRIES];
    logic [IW-1:0]    age_q   [ENTRIES];

    logic          use_en;
    logic [IW-1:0] use_idx;
    logic          free_found;

    assign use_en  = wr_en | touch_en;
    assign use_idx = wr_en ? wr_idx : touch_idx;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        hit_data = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (valid_q[j] && tag_q[j] == look_tag && !hit) begin
                hit      = 1'b1;
                hit_idx  = IW'(j);
                hit_data = data_q[j];
            end
        end
    end

    always_comb begin
        free_found = 1'b0;
        vic_idx    = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (!valid_q[j] && !free_found) begin
                free_found = 1'b1;
                vic_idx    = IW'(j);
            end
        end
        if (!free_found) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (age_q[j] == IW'(ENTRIES - 1)) vic_idx = IW'(j);
            end
        end
        vic_valid = valid_q[vic_idx];
        vic_dirty = dirty_q[vic_idx];
        vic_tag   = tag_q[vic_idx];
        vic_data  = data_q[vic_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < ENTRIES; j++) begin
                valid_q[j] <= 1'b0;
                dirty_q[j] <= 1'b0;
                tag_q[j]   <= '0;
                data_q[j]  <= '0;
                age_q[j]   <= IW'(j);
            end
        end else begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (wr_en && wr_idx == IW'(j)) begin
                    valid_q[j] <= 1'b1;
                    dirty_q[j] <= 1'b1;
                    tag_q[j]   <= wr_tag;
                    data_q[j]  <= wr_data;
                end else if (inval_en && inval_idx == IW'(j)) begin
                    valid_q[j] <= 1'b0;
                    dirty_q[j] <= 1'b0;
                end
                if (use_en) begin
                    if (use_idx == IW'(j))
                        age_q[j] <= '0;
                    else if (age_q[j] < age_q[use_idx])
                        age_q[j] <= age_q[j] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/merkle_branch_verifier.sv
module merkle_branch_verifier
    import mbv_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter int CACHE_ENTRIES = 4,
    parameter int HASH_CYC      = 3,
    localparam int NODE_W       = DEPTH + 1,
    localparam int IW           = $clog2(CACHE_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_update,
    input  logic [DEPTH-1:0]  op_page,
    input  logic [63:0]       op_meta,
    output logic              done,
    output logic              pass,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [NODE_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_HASH, ST_CHECK, ST_EVICT, ST_SIB, ST_RD, ST_RSP, ST_FINISH
    } walk_state_t;

    walk_state_t state_q, state_d;

    logic [NODE_W-1:0] node_q;
    digest_t           cur_q, root_q;
    logic              upd_q, pass_q;

    logic              hash_start, hash_done;
    digest_t           hash_a, hash_b, hash_res, sib_val;
    logic [NODE_W-1:0] look_tag, vic_tag;
    logic              hit, vic_valid, vic_dirty;
    logic [IW-1:0]     hit_idx, vic_idx;
    digest_t           hit_data, vic_data;
    logic              wr_en, touch_en, inval_en, at_root;
    logic [IW-1:0]     wr_idx;

    assign at_root  = (node_q == NODE_W'(1));
    assign look_tag = (state_q == ST_SIB) ? (node_q ^ NODE_W'(1)) : node_q;
    assign sib_val  = (state_q == ST_SIB) ? hit_data : mem_rsp_data;

    mbv_hash #(.HASH_CYC(HASH_CYC)) u_hash (
        .clk(clk), .rst_n(rst_n), .start(hash_start),
        .in_a(hash_a), .in_b(hash_b), .done(hash_done), .result(hash_res)
    );

    mbv_node_cache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(NODE_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .look_tag(look_tag),
        .hit(hit), .hit_idx(hit_idx), .hit_data(hit_data),
        .vic_idx(vic_idx), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag), .vic_data(vic_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(node_q), .wr_data(cur_q),
        .touch_en(touch_en), .touch_idx(hit_idx),
        .inval_en(inval_en), .inval_idx(vic_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid) state_d = ST_HASH;
            ST_HASH:   if (hash_done) state_d = ST_CHECK;
            ST_CHECK: begin
                if (at_root)                               state_d = ST_FINISH;
                else if (!upd_q)                           state_d = hit ? ST_FINISH : ST_SIB;
                else if (!hit && vic_valid && vic_dirty)   state_d = ST_EVICT;
                else                                       state_d = ST_SIB;
            end
            ST_EVICT:  if (mem_req_ready) state_d = ST_CHECK;
            ST_SIB:    state_d = hit ? ST_HASH : ST_RD;
            ST_RD:     if (mem_req_ready) state_d = ST_RSP;
            ST_RSP:    if (mem_rsp_valid) state_d = ST_HASH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready      = (state_q == ST_IDLE);
        done          = (state_q == ST_FINISH);
        pass          = done && pass_q;
        mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_RD);
        mem_req_write = (state_q == ST_EVICT);
        mem_req_addr  = mem_req_write ? vic_tag : (node_q ^ NODE_W'(1));
        mem_req_wdata = vic_data;
        hash_start    = (state_q == ST_IDLE && op_valid) ||
                        (state_q == ST_SIB && hit) ||
                        (state_q == ST_RSP && mem_rsp_valid);
        if (state_q == ST_IDLE) begin
            hash_a = op_meta;
            hash_b = 64'(op_page);
        end else if (node_q[0]) begin
            hash_a = sib_val;
            hash_b = cur_q;
        end else begin
            hash_a = cur_q;
            hash_b = sib_val;
        end
        wr_en    = (state_q == ST_CHECK) && upd_q && !at_root &&
                   (hit || !(vic_valid && vic_dirty));
        wr_idx   = hit ? hit_idx : vic_idx;
        touch_en = hit && ((state_q == ST_SIB) ||
                   (state_q == ST_CHECK && !upd_q && !at_root));
        inval_en = (state_q == ST_EVICT) && mem_req_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q <= '0;
            cur_q  <= '0;
            root_q <= '0;
            upd_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && op_valid) begin
                node_q <= {1'b1, op_page};
                upd_q  <= op_update;
                pass_q <= 1'b0;
            end
            if (state_q == ST_HASH && hash_done) cur_q <= hash_res;
            if (hash_start && state_q != ST_IDLE) node_q <= node_q >> 1;
            if (state_q == ST_CHECK) begin
                if (at_root) begin
                    if (upd_q) begin
                        root_q <= cur_q;
                        pass_q <= 1'b1;
                    end else begin
                        pass_q <= (cur_q == root_q);
                    end
                end else if (!upd_q && hit) begin
                    pass_q <= (hit_data == cur_q);
                end
            end
        end
    end
endmodule

// File: rtl/merkle_branch_verifier_checker.sv
module merkle_branch_verifier_checker #(
    parameter int NODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              done,
    input logic              pass,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [NODE_W-1:0] mem_req_addr
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> op_ready);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req_valid);

    assert_pass_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !done) |-> 1'b0 == pass);
endmodule

bind merkle_branch_verifier merkle_branch_verifier_checker #(.NODE_W(NODE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .done(done), .pass(pass), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr)
);

// File: tb/merkle_branch_verifier_test.sv
`timescale 1ns/1ps
module merkle_branch_verifier_test;
    localparam int DEPTH  = 4;
    localparam int LEAVES = 1 << DEPTH;
    localparam int NODES  = 2 * LEAVES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic              op_ready;
    logic              op_update = 1'b0;
    logic [DEPTH-1:0]  op_page = '0;
    logic [63:0]       op_meta = '0;
    logic              done, pass;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [DEPTH:0]    mem_req_addr;
    logic [63:0]       mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [7:0]  cyc = '0;
    logic [63:0] mem   [NODES];
    logic [63:0] model [NODES];
    logic [63:0] metas [LEAVES];
    logic [DEPTH:0] wlog_addr [16];

    always #4 clk = ~clk;

    merkle_branch_verifier uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_update(op_update), .op_page(op_page), .op_meta(op_meta),
        .done(done), .pass(pass), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [63:0] ref_mix(logic [63:0] a, logic [63:0] b);
        logic [63:0] v;
        v = a ^ ((b << 32) | (b >> 32)) ^ 64'h9E3779B97F4A7C15;
        v = v ^ (v >> 29);
        v = v + (b << 3);
        v = v ^ ((v << 13) | (v >> 51));
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_set(input int p, input logic [63:0] meta);
        int k;
        metas[p] = meta;
        k = LEAVES + p;
        model[k] = ref_mix(meta, 64'(p));
        k = k / 2;
        while (k >= 1) begin
            model[k] = ref_mix(model[2*k], model[2*k+1]);
            k = k / 2;
        end
    endtask

    // Memory model: ready drops one cycle in four, read data one cycle after acceptance
    always @(posedge clk) begin
        cyc <= cyc + 1'b1;
        mem_req_ready <= (cyc[1:0] != 2'b11);
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                checks++;
                if (mem_req_wdata !== model[mem_req_addr]) begin
                    fails++;
                    $display("FAIL R8 writeback node %0d: actual %h expected %h",
                             mem_req_addr, mem_req_wdata, model[mem_req_addr]);
                end
                mem[mem_req_addr] = mem_req_wdata;
                if (wr_cnt < 16) wlog_addr[wr_cnt] = mem_req_addr;
                wr_cnt++;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr];
                rd_cnt++;
            end
        end
    end

    task automatic run_op(input string req, input logic upd, input int p,
                          input logic [63:0] meta, output logic res);
        int n;
        @(negedge clk);
        op_valid  = 1'b1;
        op_update = upd;
        op_page   = DEPTH'(p);
        op_meta   = meta;
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " R9 busy after accept"}, 64'(op_ready), 64'd0);
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " R9 completes"}, 64'(done), 64'd1);
        res = pass;
        @(negedge clk);
        check({req, " R9 done single pulse"}, 64'(done), 64'd0);
        check({req, " R9 ready after done"}, 64'(op_ready), 64'd1);
    endtask

    task automatic t_reset;
        logic r;
        check("R1 op_ready", 64'(op_ready), 64'd1);
        check("R1 done", 64'(done), 64'd0);
        check("R1 no request", 64'(mem_req_valid), 64'd0);
        run_op("R1", 1'b0, 3, 64'd0, r);
        check("R1 zero root fails verify", 64'(r), 64'd0);
    endtask

    task automatic t_first_update;
        logic r; int rd0, wr0;
        rd0 = rd_cnt; wr0 = wr_cnt;
        run_op("R5", 1'b1, 0, 64'hA5A5_0000_1234_5678, r);
        model_set(0, 64'hA5A5_0000_1234_5678);
        check("R5 update pass", 64'(r), 64'd1);
        check("R7 four sibling reads", 64'(rd_cnt - rd0), 64'd4);
        check("R8 no writeback while slots free", 64'(wr_cnt - wr0), 64'd0);
    endtask

    task automatic t_cached_leaf;
        logic r; int rd0;
        rd0 = rd_cnt;
        run_op("R6", 1'b0, 0, metas[0], r);
        check("R6 cached leaf pass", 64'(r), 64'd1);
        check("R6 no memory request", 64'(rd_cnt - rd0), 64'd0);
    endtask

    task automatic t_sibling_hit;
        logic r; int rd0;
        rd0 = rd_cnt;
        run_op("R3", 1'b0, 1, metas[1], r);
        check("R3 stop at cached parent pass", 64'(r), 64'd1);
        check("R7 sibling taken from cache", 64'(rd_cnt - rd0), 64'd0);
    endtask

    task automatic t_bad_meta;
        logic r;
        run_op("R4", 1'b0, 2, metas[2] ^ 64'd1, r);
        check("R4 wrong descriptor fails", 64'(r), 64'd0);
    endtask

    task automatic t_tamper;
        logic r; logic [63:0] keep;
        keep = mem[19];
        mem[19] = keep ^ 64'h8000_0000_0000_0000;
        run_op("R4", 1'b0, 2, metas[2], r);
        check("R4 tampered sibling fails", 64'(r), 64'd0);
        mem[19] = keep;
    endtask

    task automatic t_mem_sibling;
        logic r; int rd0;
        rd0 = rd_cnt;
        run_op("R2", 1'b0, 2, metas[2], r);
        check("R2 leaf and parent digests pass", 64'(r), 64'd1);
        check("R7 one sibling read", 64'(rd_cnt - rd0), 64'd1);
    endtask

    task automatic t_evict;
        logic r; int wr0;
        wr0 = wr_cnt;
        run_op("R8", 1'b1, 15, 64'h0BAD_F00D_CAFE_0015, r);
        model_set(15, 64'h0BAD_F00D_CAFE_0015);
        check("R8 update pass", 64'(r), 64'd1);
        check("R8 four writebacks", 64'(wr_cnt - wr0), 64'd4);
        check("R8 LRU order 1st", 64'(wlog_addr[wr0]),   64'd2);
        check("R8 LRU order 2nd", 64'(wlog_addr[wr0+1]), 64'd16);
        check("R8 LRU order 3rd", 64'(wlog_addr[wr0+2]), 64'd8);
        check("R8 LRU order 4th", 64'(wlog_addr[wr0+3]), 64'd4);
        run_op("R8", 1'b0, 0, metas[0], r);
        check("R8 evicted branch still verifies", 64'(r), 64'd1);
        run_op("R5", 1'b0, 15, metas[15], r);
        check("R5 new descriptor verifies", 64'(r), 64'd1);
        run_op("R4", 1'b0, 15, metas[0], r);
        check("R4 stale descriptor fails", 64'(r), 64'd0);
    endtask

    task automatic t_sweep;
        logic r;
        run_op("R5", 1'b1, 5, 64'h5555_AAAA_0F0F_F0F0, r);
        model_set(5, 64'h5555_AAAA_0F0F_F0F0);
        check("R5 second update pass", 64'(r), 64'd1);
        for (int p = 0; p < LEAVES; p++) begin
            run_op("R3", 1'b0, p, metas[p], r);
            check("R3 sweep verify", 64'(r), 64'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < LEAVES; p++) metas[p] = '0;
        model[0] = '0;
        for (int p = 0; p < LEAVES; p++) model[LEAVES + p] = ref_mix(64'd0, 64'(p));
        for (int k = LEAVES - 1; k >= 1; k--) model[k] = ref_mix(model[2*k], model[2*k+1]);
        for (int k = 0; k < NODES; k++) mem[k] = model[k];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_first_update;
        t_cached_leaf;
        t_sibling_hit;
        t_bad_meta;
        t_tamper;
        t_mem_sibling;
        t_evict;
        t_sweep;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule